// File: doc/BRIEF.md
# Single-Line Open-Drain Bus Master

This block is the only master on a one-wire, open-drain serial bus. The bus idles high through an external resistor. The master never drives the line high. It either pulls the line low or lets it go. The block accepts one command at a time through a valid-qualified port:

- A bus reset: a long low pulse, followed by a listen window in which attached devices may signal that they are there.
- A byte write: eight time slots, least significant bit first.
- A byte read: eight time slots whose waveform matches a write of all ones. The line is sampled once in each slot.

All timing is given as clock-cycle counts in parameters.

A byte write can ask for a high-current supply phase. When the last slot ends, the block raises a strong-pullup enable for an external switch. The enable stays up until the host pulses a clear input. While it is up, the master starts no slot and accepts no command. This keeps the line free for the device that draws the extra current. Between commands, and during the recovery part of every slot, the line is released. This lets a paused transaction resume at any later time.

Top module: `owm_master`

## Requirements
- R1: After reset, `bus_low`, `busy`, `done` and `spu_en` are 0, and `rx_byte` and `presence` read 0.
- R2: A reset command (`cmd_op` = 2'b01) holds `bus_low` high for exactly RST_LOW_CYC cycles, starting in the cycle after acceptance. It then releases the line for RST_WIN_CYC more cycles before finishing.
- R3: The line is sampled RST_LOW_CYC+PRES_DLY_CYC cycles after the reset pulse starts. `presence` becomes 1 if the line was low at that point and 0 if it was high.
- R4: A write command (`cmd_op` = 2'b10) sends `tx_byte` bit 0 first, in eight back-to-back slots of SLOT_CYC+REC_CYC cycles each.
- R5: In a slot carrying a 1, the line is low for LOW1_CYC cycles. In a slot carrying a 0, it is low for LOW0_CYC cycles. The line is released for the rest of the slot.
- R6: A read command (`cmd_op` = 2'b11) drives slots shaped as write-1 slots. In each slot it samples the line RD_SMP_CYC cycles after the slot starts. The first bit read becomes bit 0 of `rx_byte`, and `rx_byte` is updated when the command completes.
- R7: `busy` rises in the cycle after a command is accepted. `done` is a one-cycle pulse in the first cycle in which `busy` is low again.
- R8: A command is accepted only when the block is idle and `cmd_op` is not 2'b00. A request while `busy` is high, or with `cmd_op` = 2'b00, leaves the line and all outputs unchanged.
- R9: A write with `cmd_spu` = 1 raises `spu_en` in the same cycle as `done`. `spu_en` stays high until a cycle with `spu_off` = 1. A read with `cmd_spu` = 1 leaves `spu_en` low.
- R10: While `spu_en` is high, every command is ignored and the line stays released.
- R11: `bus_low` is high only while a command is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 00 none, 01 bus reset, 10 write byte, 11 read byte |
| cmd_spu | input | 1 | Raise strong pullup after this write |
| tx_byte | input | BYTE_W | Byte to write |
| spu_off | input | 1 | Drops the strong-pullup enable |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_byte | output | BYTE_W | Last byte read |
| presence | output | 1 | Result of the last reset's presence sample |
| bus_low | output | 1 | Pull the line low (open-drain enable) |
| bus_in | input | 1 | Sampled line level |
| spu_en | output | 1 | Strong-pullup switch enable |

## Verification
The bound checks run on every cycle. They cover these rules:
- The line is released whenever the block is idle or the strong pullup is on.
- `done` lasts one cycle and coincides with the end of `busy`.
- `spu_en` holds until it is cleared.
- Every low pulse has one of the three legal widths.

Only the bench scenarios can show the following:
- Bit order on the line.
- Which width each data bit produced.
- The exact cycle of the presence and read samples, exercised by a slave model that answers through the open-drain line.
- That requests arriving mid-command, with the null code, or during the strong-pullup phase leave the waveform untouched.

// File: rtl/owm_pkg.sv
// Shared encodings for the single-line bus master.
// Assumes a two-bit command code at the block's edge.
package owm_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_RESET = 2'b01,
        OP_WRITE = 2'b10,
        OP_READ  = 2'b11
    } owm_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_RESET = 2'b01,
        ST_SLOT  = 2'b10
    } owm_state_e;

endpackage

// File: rtl/owm_timer.sv
// Phase counter: counts clock cycles inside the current reset window or slot.
// Assumes the sequencer clears it at every phase start; it holds while idle.
module owm_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          run,
    output logic [CW-1:0] cnt
);

    // Advance while a command is running; restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (run)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/owm_shifter.sv
// LSB-first byte shifter shared by writes and reads.
// Bit 0 is the bit of the current slot. Each shift moves the next bit
// into position 0 and enters the sampled bit at the top.
module owm_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         shift_in,
    output logic [W-1:0] data
);

    // Load at command start, shift right at every slot end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data <= '0;
        else if (load)
            data <= load_val;
        else if (shift)
            data <= {shift_in, data[W-1:1]};
    end

endmodule

// File: rtl/owm_seq.sv
// Sequencer for the bus master: command acceptance, reset/presence window,
// slot timing, sampling points and strong-pullup flag.
// Assumes cnt restarts at 0 in the first cycle of each phase and that
// RD_SMP_CYC < SLOT_CYC+REC_CYC-1 and LOW0_CYC <= SLOT_CYC.
module owm_seq
    import owm_pkg::*;
#(
    parameter int RST_LOW_CYC  = 48000,
    parameter int RST_WIN_CYC  = 48000,
    parameter int PRES_DLY_CYC = 7000,
    parameter int LOW1_CYC     = 600,
    parameter int LOW0_CYC     = 6000,
    parameter int RD_SMP_CYC   = 1500,
    parameter int SLOT_CYC     = 6000,
    parameter int REC_CYC      = 100,
    parameter int BYTE_W       = 8,
    parameter int CW           = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic          cmd_spu,
    input  logic          spu_off,
    input  logic          bus_in,
    input  logic [CW-1:0] cnt,
    input  logic          cur_bit,
    output logic          tmr_clr,
    output logic          sh_load,
    output logic          sh_fill,
    output logic          sh_shift,
    output logic          samp_bit,
    output logic          rx_commit,
    output logic          bus_low,
    output logic          busy,
    output logic          done,
    output logic          presence,
    output logic          spu_en
);

    localparam int BW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [CW-1:0] RST_REL  = CW'(RST_LOW_CYC);
    localparam logic [CW-1:0] RST_SMP  = CW'(RST_LOW_CYC + PRES_DLY_CYC);
    localparam logic [CW-1:0] RST_END  = CW'(RST_LOW_CYC + RST_WIN_CYC - 1);
    localparam logic [CW-1:0] SLOT_END = CW'(SLOT_CYC + REC_CYC - 1);
    localparam logic [CW-1:0] RD_AT    = CW'(RD_SMP_CYC);
    localparam logic [CW-1:0] LOW1_C   = CW'(LOW1_CYC);
    localparam logic [CW-1:0] LOW0_C   = CW'(LOW0_CYC);
    localparam logic [BW-1:0] LAST_IDX = BW'(BYTE_W - 1);

    owm_state_e    state;
    owm_op_e       op;
    logic [BW-1:0] bit_idx;
    logic          is_read;
    logic          spu_req;
    logic          accept;
    logic          slot_end;
    logic          last_bit;

    assign op       = owm_op_e'(cmd_op);
    assign accept   = cmd_valid && (state == ST_IDLE) && !spu_en && (op != OP_NONE);
    assign slot_end = (state == ST_SLOT) && (cnt == SLOT_END);
    assign last_bit = (bit_idx == LAST_IDX);
    assign busy     = (state != ST_IDLE);

    // Datapath strobes derived from acceptance and slot boundaries.
    always_comb begin
        tmr_clr   = accept || slot_end;
        sh_load   = accept && (op != OP_RESET);
        sh_fill   = (op == OP_READ);
        sh_shift  = slot_end;
        rx_commit = slot_end && last_bit && is_read;
    end

    // Open-drain enable: low during the reset pulse or the head of a slot.
    always_comb begin
        bus_low = 1'b0;
        if (state == ST_RESET)
            bus_low = (cnt < RST_REL);
        else if (state == ST_SLOT)
            bus_low = (cnt < (cur_bit ? LOW1_C : LOW0_C));
    end

    // Phase sequencing, sample capture, completion pulse and pullup flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_idx  <= '0;
            is_read  <= 1'b0;
            spu_req  <= 1'b0;
            samp_bit <= 1'b0;
            done     <= 1'b0;
            presence <= 1'b0;
            spu_en   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (spu_en && spu_off)
                spu_en <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        bit_idx <= '0;
                        is_read <= (op == OP_READ);
                        spu_req <= cmd_spu && (op == OP_WRITE);
                        state   <= (op == OP_RESET) ? ST_RESET : ST_SLOT;
                    end
                end
                ST_RESET: begin
                    if (cnt == RST_SMP)
                        presence <= !bus_in;
                    if (cnt == RST_END) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                ST_SLOT: begin
                    if (cnt == RD_AT)
                        samp_bit <= bus_in;
                    if (slot_end) begin
                        if (last_bit) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                            if (spu_req)
                                spu_en <= 1'b1;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/owm_master.sv
// Top of the single-line bus master. It joins the sequencer, the phase
// counter and the byte shifter, and holds the received byte.
// Assumes an external pull-up resistor and an external open-drain driver
// controlled by bus_low. All timing is in clock cycles.
module owm_master #(
    parameter int RST_LOW_CYC  = 48000,
    parameter int RST_WIN_CYC  = 48000,
    parameter int PRES_DLY_CYC = 7000,
    parameter int LOW1_CYC     = 600,
    parameter int LOW0_CYC     = 6000,
    parameter int RD_SMP_CYC   = 1500,
    parameter int SLOT_CYC     = 6000,
    parameter int REC_CYC      = 100,
    parameter int BYTE_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic              cmd_spu,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              spu_off,
    output logic              busy,
    output logic              done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              presence,
    output logic              bus_low,
    input  logic              bus_in,
    output logic              spu_en
);

    localparam int RST_TOT  = RST_LOW_CYC + RST_WIN_CYC;
    localparam int SLOT_TOT = SLOT_CYC + REC_CYC;
    localparam int MAX_TOT  = (RST_TOT > SLOT_TOT) ? RST_TOT : SLOT_TOT;
    localparam int CW       = $clog2(MAX_TOT) + 1;

    logic [CW-1:0]     cnt;
    logic [BYTE_W-1:0] sh_data;
    logic              tmr_clr;
    logic              sh_load;
    logic              sh_fill;
    logic              sh_shift;
    logic              samp_bit;
    logic              rx_commit;

    owm_seq #(
        .RST_LOW_CYC (RST_LOW_CYC),
        .RST_WIN_CYC (RST_WIN_CYC),
        .PRES_DLY_CYC(PRES_DLY_CYC),
        .LOW1_CYC    (LOW1_CYC),
        .LOW0_CYC    (LOW0_CYC),
        .RD_SMP_CYC  (RD_SMP_CYC),
        .SLOT_CYC    (SLOT_CYC),
        .REC_CYC     (REC_CYC),
        .BYTE_W      (BYTE_W),
        .CW          (CW)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_op   (cmd_op),
        .cmd_spu  (cmd_spu),
        .spu_off  (spu_off),
        .bus_in   (bus_in),
        .cnt      (cnt),
        .cur_bit  (sh_data[0]),
        .tmr_clr  (tmr_clr),
        .sh_load  (sh_load),
        .sh_fill  (sh_fill),
        .sh_shift (sh_shift),
        .samp_bit (samp_bit),
        .rx_commit(rx_commit),
        .bus_low  (bus_low),
        .busy     (busy),
        .done     (done),
        .presence (presence),
        .spu_en   (spu_en)
    );

    owm_timer #(
        .CW(CW)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(tmr_clr),
        .run  (busy),
        .cnt  (cnt)
    );

    owm_shifter #(
        .W(BYTE_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sh_load),
        .load_val(sh_fill ? {BYTE_W{1'b1}} : tx_byte),
        .shift   (sh_shift),
        .shift_in(samp_bit),
        .data    (sh_data)
    );

    // Latch the assembled byte when a read's last slot ends.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_byte <= '0;
        else if (rx_commit)
            rx_byte <= {samp_bit, sh_data[BYTE_W-1:1]};
    end

endmodule

// File: rtl/owm_checks.sv
// Protocol checks for owm_master, attached through bind.
// Tracks the length of each low pulse with its own counter.
module owm_checks #(
    parameter int RST_LOW_CYC = 48000,
    parameter int LOW1_CYC    = 600,
    parameter int LOW0_CYC    = 6000
) (
    input logic clk,
    input logic rst_n,
    input logic bus_low,
    input logic busy,
    input logic done,
    input logic spu_en,
    input logic spu_off
);

    logic [31:0] run_len;
    logic        low_q;

    // Measure the current low pulse in cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
            low_q   <= 1'b0;
        end else begin
            low_q <= bus_low;
            if (bus_low)
                run_len <= low_q ? run_len + 1 : 32'd1;
        end
    end

    assert_idle_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_low);

    assert_spu_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        spu_en |-> (!bus_low && !busy));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    assert_spu_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (spu_en && !spu_off) |=> spu_en);

    assert_low_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (low_q && !bus_low) |-> (run_len == 32'(LOW1_CYC) || run_len == 32'(LOW0_CYC)
                                 || run_len == 32'(RST_LOW_CYC)));

endmodule

bind owm_master owm_checks #(
    .RST_LOW_CYC(RST_LOW_CYC),
    .LOW1_CYC   (LOW1_CYC),
    .LOW0_CYC   (LOW0_CYC)
) u_owm_checks (
    .clk    (clk),
    .rst_n  (rst_n),
    .bus_low(bus_low),
    .busy   (busy),
    .done   (done),
    .spu_en (spu_en),
    .spu_off(spu_off)
);

// File: tb/test_owm_master.sv
// Bench for owm_master. It holds a queue of expected per-cycle port values
// {bus_low, busy, done, spu_en} and an open-drain slave model that times
// pulses, answers presence and serves read bits.
module test_owm_master;

    localparam int RL = 40, RW = 40, PD = 10, L1 = 3, L0 = 20, RS = 6, SL = 24, RC = 2;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_valid;
    logic [1:0] cmd_op;
    logic       cmd_spu;
    logic [7:0] tx_byte;
    logic       spu_off;
    logic       busy, done, presence, bus_low, bus_in, spu_en;
    logic [7:0] rx_byte;
    logic       slv_low;

    always #5 clk = ~clk;
    assign bus_in = !(bus_low || slv_low);

    owm_master #(
        .RST_LOW_CYC(RL), .RST_WIN_CYC(RW), .PRES_DLY_CYC(PD), .LOW1_CYC(L1),
        .LOW0_CYC(L0), .RD_SMP_CYC(RS), .SLOT_CYC(SL), .REC_CYC(RC), .BYTE_W(8)
    ) i_owm_master (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_spu(cmd_spu), .tx_byte(tx_byte), .spu_off(spu_off), .busy(busy),
        .done(done), .rx_byte(rx_byte), .presence(presence), .bus_low(bus_low),
        .bus_in(bus_in), .spu_en(spu_en)
    );

    int         vectors = 0;
    int         fails = 0;
    bit         finished = 0;
    bit         chk_on = 0;
    logic [3:0] exp_q[$];
    logic       cur_spu = 1'b0;
    int         bit_q[$];
    bit         pres_en = 0;
    bit         rd_mode = 0;
    logic [7:0] slv_byte = 8'h00;
    int         slv_idx = 0;
    int         run = 0;
    int         hold = 0;
    logic       prev_low = 1'b0;

    task automatic check(input string req, input string what, input int act, input int expv);
        vectors++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, expv, $time);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    // Per-cycle comparison against the expected-port queue (R2 R4 R5 R7 R9 R10 R11).
    always @(posedge clk) begin
        logic [3:0] item;
        #2;
        if (chk_on) begin
            if (exp_q.size() != 0) begin
                item    = exp_q.pop_front();
                cur_spu = item[0];
            end else begin
                item = {3'b000, cur_spu};
            end
            check("R7", "cycle {low,busy,done,spu}", {bus_low, busy, done, spu_en}, item);
        end
    end

    // Open-drain slave: pulse timing, presence reply, read bit reply.
    always @(posedge clk) begin
        if (!rst_n) begin
            slv_low  <= 1'b0;
            hold     <= 0;
            run      <= 0;
            prev_low <= 1'b0;
        end else begin
            if (hold > 0) begin
                hold <= hold - 1;
                if (hold == 1) slv_low <= 1'b0;
            end
            if (bus_low) run <= prev_low ? run + 1 : 1;
            if (bus_low && !prev_low && rd_mode) begin
                if (!slv_byte[slv_idx[2:0]]) begin
                    slv_low <= 1'b1;
                    hold    <= RS + 4;
                end
                slv_idx <= slv_idx + 1;
            end
            if (!bus_low && prev_low) begin
                if (run == RL) begin
                    if (pres_en) begin
                        slv_low <= 1'b1;
                        hold    <= 20;
                    end
                end else if (run == L1) bit_q.push_back(1);
                else if (run == L0) bit_q.push_back(0);
                else check("R5", "low pulse width", run, L1);
            end
            prev_low <= bus_low;
        end
    end

    // Issue one request; when it should be taken, queue the expected waveform.
    task automatic run_cmd(input logic [1:0] op, input logic [7:0] d, input bit spu, input bit taken);
        logic [7:0] v;
        @(negedge clk);
        bit_q.delete();
        cmd_valid = 1'b1; cmd_op = op; tx_byte = d; cmd_spu = spu;
        if (taken) begin
            if (op == 2'b01) begin
                for (int i = 0; i < RL + RW; i++) exp_q.push_back({(i < RL), 1'b1, 1'b0, 1'b0});
                exp_q.push_back(4'b0010);
            end else begin
                v = (op == 2'b11) ? 8'hFF : d;
                for (int b = 0; b < 8; b++)
                    for (int i = 0; i < SL + RC; i++)
                        exp_q.push_back({(i < (v[b] ? L1 : L0)), 1'b1, 1'b0, 1'b0});
                exp_q.push_back({3'b001, (spu && op == 2'b10)});
            end
        end
        @(negedge clk);
        cmd_valid = 1'b0; cmd_spu = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    function automatic int bits_to_byte();
        int r = 0;
        for (int i = 0; i < 8; i++) if (i < bit_q.size() && bit_q[i] == 1) r |= (1 << i);
        return r;
    endfunction

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'b00; cmd_spu = 1'b0;
        tx_byte = 8'h00; spu_off = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "reset outputs", {bus_low, busy, done, spu_en, presence}, 0);
        check("R1", "reset rx_byte", rx_byte, 0);
        rst_n = 1'b1; chk_on = 1;
        repeat (3) @(negedge clk);

        // R2 R3: reset with and without a responding device.
        pres_en = 1;
        run_cmd(2'b01, 8'h00, 0, 1);
        check("R3", "presence with device", presence, 1);
        pres_en = 0;
        run_cmd(2'b01, 8'h00, 0, 1);
        check("R3", "presence without device", presence, 0);

        // R4 R5: writes with mixed, all-zero and all-one patterns.
        run_cmd(2'b10, 8'hA5, 0, 1);
        check("R4", "bits on line 0xA5", bits_to_byte(), 8'hA5);
        check("R4", "slot count", bit_q.size(), 8);
        run_cmd(2'b10, 8'h00, 0, 1);
        check("R5", "bits on line 0x00", bits_to_byte(), 8'h00);
        run_cmd(2'b10, 8'hFF, 0, 1);
        check("R5", "bits on line 0xFF", bits_to_byte(), 8'hFF);

        // R6: reads served by the slave.
        rd_mode = 1; slv_byte = 8'h3C; slv_idx = 0;
        run_cmd(2'b11, 8'h00, 0, 1);
        check("R6", "rx_byte 0x3C", rx_byte, 8'h3C);
        slv_byte = 8'h81; slv_idx = 0;
        run_cmd(2'b11, 8'h00, 1, 1);
        check("R6", "rx_byte 0x81", rx_byte, 8'h81);
        check("R9", "no pullup after read", spu_en, 0);
        rd_mode = 0;

        // R8: a request during a write and a null code are both ignored.
        fork
            run_cmd(2'b10, 8'h5A, 0, 1);
            begin
                repeat (40) @(negedge clk);
                cmd_valid = 1'b1; cmd_op = 2'b01;
                @(negedge clk);
                cmd_valid = 1'b0;
            end
        join
        check("R8", "byte unharmed by busy request", bits_to_byte(), 8'h5A);
        run_cmd(2'b00, 8'h77, 0, 0);
        check("R8", "null code no pulses", bit_q.size(), 0);

        // R9 R10: strong pullup after a write, then a blocked request.
        run_cmd(2'b10, 8'hCC, 1, 1);
        check("R9", "pullup raised", spu_en, 1);
        run_cmd(2'b01, 8'h00, 0, 0);
        check("R10", "no pulses while pullup on", bit_q.size(), 0);
        check("R9", "pullup still held", spu_en, 1);
        @(negedge clk);
        spu_off = 1'b1; cur_spu = 1'b0;
        @(negedge clk);
        spu_off = 1'b0;
        repeat (2) @(negedge clk);
        check("R9", "pullup cleared", spu_en, 0);
        pres_en = 1;
        run_cmd(2'b01, 8'h00, 0, 1);
        check("R10", "reset works after clear", presence, 1);

        report();
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R7 watchdog actual=hung expected=finished");
        report();
    end

endmodule